// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block sits after the clock synthesizers and decides, cycle by cycle, whether each group of clock outputs may pass its source clock. It takes an internally generated CPU clock and PCI clock, plus three active-low requests: stop the CPU clocks, stop the PCI clocks, and power down. It drives a bank of gated CPU clocks, a bank of gated PCI clocks, and one PCI clock that only power-down can stop.

Every request is brought into the clock domain it controls through a two-flop synchronizer on the rising edge. A small state machine per domain runs on the falling edge. An enable register, also clocked on the falling edge, is ANDed with the source clock. The enable can change only while the clock is low, so a stop or restart always removes or adds whole high pulses and never truncates one. The free PCI output has its own gate, and that gate sees only the power-down request.

Each domain gate has three states. GS_RUN passes the clock. GS_PARK holds the outputs low because of a stop request. GS_HOLD holds the outputs low because of power-down, and it is also the state after reset. The transitions are:
- RUN→HOLD on a power-down request.
- RUN→PARK on a stop request.
- PARK→HOLD on a power-down request.
- PARK→RUN when the stop request is released.
- HOLD→PARK when power-down is released while a stop request is still present.
- HOLD→RUN when power-down is released and no stop request is present.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While rst_n is low, every output is 0. After reset is released with no request active, the outputs stay low until the third rising edge of their source clock.
- R2: If cpu_stop_n falls during a low phase of cpu_clk_i, the CPU outputs give exactly two more high pulses, on the next two rising edges, and then stay at 0.
- R3: If cpu_stop_n rises during a low phase, the first CPU output pulse comes on the third rising edge after the change.
- R4: pci_stop_n is sampled on rising edges of the PCI clock and follows the same latency as R2 and R3. While pci_stop_n is stopping them, the gated PCI outputs stay at 0.
- R5: pci_free_o is never affected by pci_stop_n. Its pulses follow only power-down.
- R6: If pwr_dn_n falls, all outputs, including pci_free_o, stop low after two more whole pulses in their own domains.
- R7: After pwr_dn_n rises, the CPU outputs and pci_free_o resume on the third rising edge of their domains. The gated PCI outputs resume then only if pci_stop_n is high; otherwise they stay low.
- R8: Every high pulse on any output lasts exactly half a source period, and every output is 0 during the low phase of its source clock.
- R9: A CPU stop request has no effect on the PCI outputs, and a PCI stop request has no effect on the CPU outputs.
- R10: All copies within one output bank are identical at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk_i | input | 1 | Free-running CPU source clock |
| pci_clk_i | input | 1 | Free-running PCI source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Active-low request to park the CPU outputs |
| pci_stop_n | input | 1 | Active-low request to park the gated PCI outputs |
| pwr_dn_n | input | 1 | Active-low power-down request for all outputs |
| cpu_clk_o | output | N_CPU | Gated CPU clock copies |
| pci_clk_o | output | N_PCI | Gated PCI clock copies |
| pci_free_o | output | 1 | PCI clock stopped only by power-down |

## Verification
Each result is due on the third rising edge of its domain clock after a request changes during a low phase. That edge comes after two synchronizer edges and one falling-edge enable update. The bench changes requests only 5 ns after a PCI falling edge, which falls in the low phase of both clocks. A per-domain history of the request level sampled at each rising edge gives the expected output two edges later. That value is compared 3 ns into the high phase, and 3 ns into each low phase the outputs are checked for 0. Pulse widths are timed from edge to edge, so a truncated or extra pulse shows up as a width error as well as a level error.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    // Gate states; GS_RUN is the only state that lets the clock through.
    typedef enum logic [1:0] {
        GS_HOLD = 2'b00,   // parked by power-down (also reset state)
        GS_RUN  = 2'b01,   // clock passes
        GS_PARK = 2'b10    // parked by a stop request
    } gate_state_e;

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
    parameter int unsigned STAGES    = 2,
    parameter bit          RESET_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= (chain_q << 1) | STAGES'(d_i);
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate
    import clkstop_pkg::*;
#(
    parameter int unsigned STAGES = 2,
    parameter int unsigned N_OUT  = 1
) (
    input  logic             clk_i,
    input  logic             rst_n,
    input  logic             stop_req_i,   // active high, asynchronous
    input  logic             pd_req_i,     // active high, asynchronous
    output logic [N_OUT-1:0] clk_o
);

    logic        stop_s;
    logic        pd_s;
    gate_state_e state_q;
    gate_state_e state_d;
    logic        run_d;
    logic        en_q;

    clkstop_sync #(.STAGES(STAGES), .RESET_VAL(1'b1)) u_sync_stop (
        .clk_i (clk_i),
        .rst_n (rst_n),
        .d_i   (stop_req_i),
        .q_o   (stop_s)
    );

    clkstop_sync #(.STAGES(STAGES), .RESET_VAL(1'b1)) u_sync_pd (
        .clk_i (clk_i),
        .rst_n (rst_n),
        .d_i   (pd_req_i),
        .q_o   (pd_s)
    );

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_RUN: begin
                if (pd_s)        state_d = GS_HOLD;
                else if (stop_s) state_d = GS_PARK;
            end
            GS_PARK: begin
                if (pd_s)         state_d = GS_HOLD;
                else if (!stop_s) state_d = GS_RUN;
            end
            GS_HOLD: begin
                if (!pd_s) state_d = stop_s ? GS_PARK : GS_RUN;
            end
            default: state_d = GS_HOLD;
        endcase
    end

    // Output decode: enable follows the state being entered
    always_comb begin
        run_d = (state_d == GS_RUN);
    end

    // State and enable registers move only while the clock is low
    always_ff @(negedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GS_HOLD;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            en_q    <= run_d;
        end
    end

    // Fan out the gated clock
    for (genvar g = 0; g < N_OUT; g++) begin : g_fan
        assign clk_o[g] = clk_i & en_q;
    end

    // A synchronized power-down parks the gate at the next falling edge
    assert_pd_parks_R6: assert property (@(negedge clk_i) disable iff (!rst_n)
        pd_s |=> !en_q);

    // A synchronized stop parks the gate at the next falling edge
    assert_stop_parks_R2: assert property (@(negedge clk_i) disable iff (!rst_n)
        stop_s |=> !en_q);

    // With both requests clear the gate opens at the next falling edge
    assert_resume_R3: assert property (@(negedge clk_i) disable iff (!rst_n)
        (!pd_s && !stop_s) |=> en_q);

    // Leaving power-down only after the synchronized request clears
    assert_hold_keeps_R7: assert property (@(negedge clk_i) disable iff (!rst_n)
        (state_q == GS_HOLD && pd_s) |=> (state_q == GS_HOLD));

endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl #(
    parameter int unsigned N_CPU  = 2,
    parameter int unsigned N_PCI  = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic             cpu_clk_i,
    input  logic             pci_clk_i,
    input  logic             rst_n,
    input  logic             cpu_stop_n,
    input  logic             pci_stop_n,
    input  logic             pwr_dn_n,
    output logic [N_CPU-1:0] cpu_clk_o,
    output logic [N_PCI-1:0] pci_clk_o,
    output logic             pci_free_o
);

    logic pd_req;
    assign pd_req = ~pwr_dn_n;

    clkstop_gate #(.STAGES(STAGES), .N_OUT(N_CPU)) u_cpu_gate (
        .clk_i      (cpu_clk_i),
        .rst_n      (rst_n),
        .stop_req_i (~cpu_stop_n),
        .pd_req_i   (pd_req),
        .clk_o      (cpu_clk_o)
    );

    clkstop_gate #(.STAGES(STAGES), .N_OUT(N_PCI)) u_pci_gate (
        .clk_i      (pci_clk_i),
        .rst_n      (rst_n),
        .stop_req_i (~pci_stop_n),
        .pd_req_i   (pd_req),
        .clk_o      (pci_clk_o)
    );

    clkstop_gate #(.STAGES(STAGES), .N_OUT(1)) u_free_gate (
        .clk_i      (pci_clk_i),
        .rst_n      (rst_n),
        .stop_req_i (1'b0),
        .pd_req_i   (pd_req),
        .clk_o      (pci_free_o)
    );

    // A gated PCI pulse is always accompanied by a free PCI pulse
    assert_free_covers_R5: assert property (@(negedge pci_clk_i) disable iff (!rst_n)
        pci_clk_o[0] |-> pci_free_o);

endmodule

// File: tb/clk_stop_ctrl_tb.sv
`timescale 1ns/1ps
module clk_stop_ctrl_tb;

    localparam int NC = 2;
    localparam int NP = 5;

    logic cpu_clk = 1'b0;
    logic pci_clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_stop_n = 1'b1;
    logic pci_stop_n = 1'b1;
    logic pwr_dn_n = 1'b1;
    logic [NC-1:0] cpu_o;
    logic [NP-1:0] pci_o;
    logic free_o;

    int checks = 0;
    int errors = 0;

    always #10 cpu_clk = ~cpu_clk;   // 50 MHz
    always #20 pci_clk = ~pci_clk;

    clk_stop_ctrl #(.N_CPU(NC), .N_PCI(NP), .STAGES(2)) u_dut (
        .cpu_clk_i  (cpu_clk),
        .pci_clk_i  (pci_clk),
        .rst_n      (rst_n),
        .cpu_stop_n (cpu_stop_n),
        .pci_stop_n (pci_stop_n),
        .pwr_dn_n   (pwr_dn_n),
        .cpu_clk_o  (cpu_o),
        .pci_clk_o  (pci_o),
        .pci_free_o (free_o)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    function automatic logic cpu_runs(logic stop_n, logic pd_n);
        return stop_n & pd_n;
    endfunction

    function automatic logic pci_runs(logic stop_n, logic pd_n);
        return stop_n & pd_n;
    endfunction

    function automatic logic free_runs(logic pd_n);
        return pd_n;
    endfunction

    // Request history: bit 0 = level at the last edge, bit 1 = two edges ago
    logic [1:0] hc = 2'b00;
    logic [1:0] hp = 2'b00;
    logic [1:0] hf = 2'b00;

    always @(posedge cpu_clk) begin
        logic e;
        e  = hc[1];
        hc = rst_n ? {hc[0], cpu_runs(cpu_stop_n, pwr_dn_n)} : 2'b00;
        #3;
        if (!rst_n) chk(cpu_o == '0, "R1 cpu in reset", int'(cpu_o), 0);
        else        chk(cpu_o == {NC{e}}, "R2 R3 R6 R7 R9 cpu level", int'(cpu_o), int'({NC{e}}));
        chk((cpu_o == '0) || (cpu_o == '1), "R10 cpu copies", int'(cpu_o), int'({NC{cpu_o[0]}}));
    end

    always @(posedge pci_clk) begin
        logic ep;
        logic ef;
        ep = hp[1];
        ef = hf[1];
        hp = rst_n ? {hp[0], pci_runs(pci_stop_n, pwr_dn_n)} : 2'b00;
        hf = rst_n ? {hf[0], free_runs(pwr_dn_n)} : 2'b00;
        #3;
        if (!rst_n) begin
            chk(pci_o == '0, "R1 pci in reset", int'(pci_o), 0);
            chk(free_o == 1'b0, "R1 free in reset", int'(free_o), 0);
        end else begin
            chk(pci_o == {NP{ep}}, "R4 R6 R7 R9 pci level", int'(pci_o), int'({NP{ep}}));
            chk(free_o == ef, "R5 R6 R7 free level", int'(free_o), int'(ef));
        end
        chk((pci_o == '0) || (pci_o == '1), "R10 pci copies", int'(pci_o), int'({NP{pci_o[0]}}));
    end

    always @(negedge cpu_clk) begin
        #3;
        chk(cpu_o == '0, "R8 cpu low phase", int'(cpu_o), 0);
    end

    always @(negedge pci_clk) begin
        #3;
        chk(pci_o == '0 && free_o == 1'b0, "R8 pci low phase", int'({free_o, pci_o}), 0);
    end

    // Pulse width monitors
    realtime t_c = 0.0;
    realtime t_p = 0.0;
    realtime t_f = 0.0;

    always @(posedge cpu_o[0]) t_c = $realtime;
    always @(negedge cpu_o[0]) begin
        realtime w;
        w = $realtime - t_c;
        chk(w > 9.99 && w < 10.01, "R8 cpu pulse width ns", int'(w), 10);
    end

    always @(posedge pci_o[0]) t_p = $realtime;
    always @(negedge pci_o[0]) begin
        realtime w;
        w = $realtime - t_p;
        chk(w > 19.99 && w < 20.01, "R8 pci pulse width ns", int'(w), 20);
    end

    always @(posedge free_o) t_f = $realtime;
    always @(negedge free_o) begin
        realtime w;
        w = $realtime - t_f;
        chk(w > 19.99 && w < 20.01, "R8 free pulse width ns", int'(w), 20);
    end

    // Move to 5 ns after a PCI falling edge: low phase of both clocks
    task automatic wait_slots(input int n);
        repeat (n) @(negedge pci_clk);
        #5;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        wait_slots(3);
        rst_n = 1'b1;                 // R1: restart latency after reset
        wait_slots(6);
        cpu_stop_n = 1'b0;            // R2, R9
        wait_slots(6);
        cpu_stop_n = 1'b1;            // R3
        wait_slots(6);
        pci_stop_n = 1'b0;            // R4, R5, R9
        wait_slots(6);
        pwr_dn_n = 1'b0;              // R6 with PCI already stopped
        wait_slots(6);
        pwr_dn_n = 1'b1;              // R7: free resumes, gated PCI stays low
        wait_slots(6);
        pci_stop_n = 1'b1;
        wait_slots(6);
        cpu_stop_n = 1'b0;            // short CPU stop: one slot
        wait_slots(1);
        cpu_stop_n = 1'b1;
        wait_slots(6);
        pwr_dn_n = 1'b0;              // short power-down
        wait_slots(1);
        pwr_dn_n = 1'b1;
        wait_slots(6);
        for (int i = 0; i < 400; i++) begin
            cpu_stop_n = ($urandom % 4) != 0;
            pci_stop_n = ($urandom % 4) != 0;
            pwr_dn_n   = ($urandom % 6) != 0;
            wait_slots(1 + ($urandom % 8));
        end
        cpu_stop_n = 1'b1;
        pci_stop_n = 1'b1;
        pwr_dn_n   = 1'b1;
        wait_slots(6);
        summary();
        $finish;
    end

endmodule